// File: doc/BRIEF.md
# Asymmetric GPIO Input Debounce Filter

This block cleans up a single asynchronous GPIO input before it reaches pin-status and interrupt logic. The raw pin is first brought into the system clock domain by a two-stage synchroniser. A stable-time counter then measures, in slow real-time ticks, how long the synchronised level has held. The counter runs only while a one-cycle tick enable is high. The filtered output takes a new level only once that level has lasted for the programmed debounce time.

The debounce time is a 4-bit count times a tick unit. Two select bits choose the unit from four scales, which covers ranges from under a millisecond to about a second with the same count field. A 2-bit mode field selects one of four behaviours:

- Bypass: no filtering.
- Filter both directions.
- Pass low pulses at once and filter only rising changes, which suits an active-high level trigger.
- The mirror of the previous mode, which suits an active-low level trigger.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `pin_filtered` is 0 and any stable time counted before reset is discarded.
- R2: With `cfg_mode` = 2'b00 (bypass), `pin_filtered` equals `pin_raw` delayed by exactly three rising clock edges, whatever `rtc_tick` does; even a one-cycle pulse passes.
- R3: The tick unit is chosen by {`cfg_large`,`cfg_unit`}: 2'b00 = 2 ticks, 2'b01 = 8 ticks, 2'b10 = 512 ticks, 2'b11 = 2048 ticks.
- R4: The threshold is `cfg_count` times the unit. A count of 0 acts as a count of 1, and the largest count, 15, gives 15 units.
- R5: Stable time advances only on clocks where `rtc_tick` is 1. Clocks without a tick leave it unchanged. Every change of the synchronised input restarts it from zero.
- R6: With `cfg_mode` = 2'b11 (filter both directions), a new level of either polarity reaches the output only after it has been stable for the threshold. A pulse shorter than the threshold never appears at the output.
- R7: With `cfg_mode` = 2'b01 (keep low pulses), a low level reaches the output three edges after it appears on the pin, even for a one-cycle pulse. A high level must first be stable for the threshold.
- R8: With `cfg_mode` = 2'b10 (keep high pulses), a high level reaches the output three edges after it appears on the pin. A low level must first be stable for the threshold.
- R9: When filtering, the output changes on the first clock edge after the edge that counts the tick completing the threshold. One tick earlier, the output has not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable marking one real-time clock period |
| pin_raw | input | 1 | Asynchronous raw pin level |
| cfg_count | input | CNT_W | Debounce count in units (0 acts as 1) |
| cfg_unit | input | 1 | Low bit of the tick-unit select |
| cfg_large | input | 1 | High bit of the tick-unit select |
| cfg_mode | input | 2 | 00 bypass, 01 keep low pulses, 10 keep high pulses, 11 filter both |
| pin_filtered | output | 1 | Filtered pin level |

## Verification
The bench steps the tick enable by hand. This places each check exactly one tick before and one tick after the threshold, so a counter that is off by one tick, or an output register that is missing or extra, shows up as an early or late change.

A pin pulse that returns to its old level and then holds for one tick less than the threshold catches a counter that fails to restart on a change. That counter would accept the level early. Idle stretches with no tick catch a counter that runs on the system clock.

One-cycle pulses in the two asymmetric modes and in bypass catch a filter applied to the wrong polarity. The wrong filter would either swallow a pulse that should pass or let a pulse through that should be blocked. The zero-count, largest-count and all four unit settings catch a wrong multiplier or a wrong scale decode, which would move the threshold.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  typedef enum logic [1:0] {
    FLT_BYPASS    = 2'b00,
    FLT_KEEP_LOW  = 2'b01,
    FLT_KEEP_HIGH = 2'b10,
    FLT_BOTH      = 2'b11
  } flt_mode_e;

  function automatic int unsigned pgf_max4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned pgf_unit(input logic [1:0] scale,
                                           input int unsigned u0, input int unsigned u1,
                                           input int unsigned u2, input int unsigned u3);
    case (scale)
      2'b00:   return u0;
      2'b01:   return u1;
      2'b10:   return u2;
      default: return u3;
    endcase
  endfunction

  function automatic int unsigned pgf_threshold(input int unsigned count,
                                                input int unsigned unit_ticks);
    int unsigned eff;
    eff = (count == 0) ? 1 : count;
    return eff * unit_ticks;
  endfunction

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic changing
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout     = chain[STAGES-1];
  // the synchronised value is about to take a new level on the coming edge
  assign changing = chain[STAGES-2] != chain[STAGES-1];

  p_settles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    changing |=> !$stable(dout));

endmodule

// File: rtl/pgf_stable_timer.sv
module pgf_stable_timer
  import pgf_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int U0 = 2,
  parameter int U1 = 8,
  parameter int U2 = 512,
  parameter int U3 = 2048,
  parameter int TMR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       scale,
  output logic             accept
);
  localparam logic [TMR_W-1:0] CNT_MAX = '1;

  logic [TMR_W-1:0] elapsed;
  logic [TMR_W-1:0] thr;

  always_comb begin
    thr = TMR_W'(pgf_threshold(32'(count), pgf_unit(scale, U0, U1, U2, U3)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          elapsed <= '0;
    else if (restart)                    elapsed <= '0;
    else if (tick && elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
  end

  assign accept = elapsed >= thr;

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> elapsed == '0);

  p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(elapsed));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && elapsed == CNT_MAX) |=> elapsed == CNT_MAX);

  p_thr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thr != '0);

endmodule

// File: rtl/pgf_filter_core.sv
module pgf_filter_core
  import pgf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      synced,
  input  logic      accept,
  input  flt_mode_e mode,
  output logic      filt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
    end else begin
      case (mode)
        FLT_BYPASS: filt_q <= synced;
        FLT_KEEP_LOW: begin
          if (!synced)     filt_q <= 1'b0;
          else if (accept) filt_q <= 1'b1;
        end
        FLT_KEEP_HIGH: begin
          if (synced)      filt_q <= 1'b1;
          else if (accept) filt_q <= 1'b0;
        end
        default: begin
          if (accept) filt_q <= synced;
        end
      endcase
    end
  end

  p_both_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FLT_BOTH && !accept) |=> $stable(filt_q));

  p_low_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FLT_KEEP_LOW && !synced) |=> !filt_q);

  p_rise_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FLT_KEEP_LOW && !accept && !filt_q) |=> !filt_q);

  p_high_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FLT_KEEP_HIGH && synced) |=> filt_q);

  p_fall_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FLT_KEEP_HIGH && !accept && filt_q) |=> filt_q);

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
  import pgf_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_T0     = 2,
  parameter int UNIT_T1     = 8,
  parameter int UNIT_T2     = 512,
  parameter int UNIT_T3     = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic             pin_raw,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_unit,
  input  logic             cfg_large,
  input  logic [1:0]       cfg_mode,
  output logic             pin_filtered
);
  localparam int UNIT_MAX = int'(pgf_max4(UNIT_T0, UNIT_T1, UNIT_T2, UNIT_T3));
  localparam int THR_MAX  = UNIT_MAX * ((1 << CNT_W) - 1);
  localparam int TMR_W    = $clog2(THR_MAX + 1);

  logic      pin_sync;
  logic      sync_change;
  logic      stable_ok;
  flt_mode_e mode;

  assign mode = flt_mode_e'(cfg_mode);

  pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pin_raw),
    .dout     (pin_sync),
    .changing (sync_change)
  );

  pgf_stable_timer #(
    .CNT_W (CNT_W),
    .U0    (UNIT_T0),
    .U1    (UNIT_T1),
    .U2    (UNIT_T2),
    .U3    (UNIT_T3),
    .TMR_W (TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (rtc_tick),
    .restart (sync_change),
    .count   (cfg_count),
    .scale   ({cfg_large, cfg_unit}),
    .accept  (stable_ok)
  );

  pgf_filter_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .synced (pin_sync),
    .accept (stable_ok),
    .mode   (mode),
    .filt_q (pin_filtered)
  );

  // edges since reset, saturating; lets the bypass check look three cycles back
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_bypass_chk
    p_bypass_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(cfg_mode) == 2'b00) |-> pin_filtered == $past(pin_raw, 3));
  end

endmodule

// File: tb/test_pin_glitch_filter.sv
module test_pin_glitch_filter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rtc_tick = 1'b0;
  logic       pin_raw = 1'b0;
  logic [3:0] cfg_count = 4'd3;
  logic       cfg_unit = 1'b0;
  logic       cfg_large = 1'b0;
  logic [1:0] cfg_mode = 2'b11;
  logic       pin_filtered;

  int  total = 0;
  int  bad = 0;
  int  ncyc = 0;
  bit  done = 1'b0;

  int    stamp_q[$];
  bit    val_q[$];
  string tag_q[$];

  pin_glitch_filter i_pin_glitch_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .rtc_tick     (rtc_tick),
    .pin_raw      (pin_raw),
    .cfg_count    (cfg_count),
    .cfg_unit     (cfg_unit),
    .cfg_large    (cfg_large),
    .cfg_mode     (cfg_mode),
    .pin_filtered (pin_filtered)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  // monitor: pops expectations whose sample cycle has come
  always @(negedge clk) begin
    while (stamp_q.size() > 0 && stamp_q[0] <= ncyc) begin
      int    st;
      bit    ev;
      string tg;
      st = stamp_q.pop_front();
      ev = val_q.pop_front();
      tg = tag_q.pop_front();
      total++;
      if (st != ncyc || pin_filtered !== ev) begin
        bad++;
        $display("FAIL %s: cycle %0d pin_filtered=%b expected=%b", tg, ncyc, pin_filtered, ev);
      end
    end
  end

  task automatic expect_next(input bit v, input string tag);
    stamp_q.push_back(ncyc + 1);
    val_q.push_back(v);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic settle(input bit v);
    pin_raw = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      rtc_tick = 1'b1;
      @(negedge clk);
    end
    rtc_tick = 1'b0;
  endtask

  // new level held for one tick less than threshold, then the last tick
  task automatic threshold_run(input bit v_new, input int thr, input string tag);
    settle(v_new);
    ticks(thr - 1);
    expect_next(!v_new, {tag, " one tick short"});
    ticks(1);
    expect_next(v_new, {tag, " at threshold"});
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic lg, input logic un, input logic [3:0] c);
    cfg_mode = m; cfg_large = lg; cfg_unit = un; cfg_count = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_next(1'b0, "R1 in reset");
    rst_n = 1'b1;
    expect_next(1'b0, "R1 after reset");

    // filter both, scale 00 (2 ticks), count 3 -> 6 ticks
    set_cfg(2'b11, 1'b0, 1'b0, 4'd3);
    settle(1'b1);
    ticks(5);
    repeat (10) @(negedge clk);
    expect_next(1'b0, "R5 idle cycles do not count");
    ticks(1);
    expect_next(1'b1, "R6 R9 rise accepted at threshold");
    threshold_run(1'b0, 6, "R6 R9 fall");

    // short high pulse rejected, restart on every change
    settle(1'b1);
    ticks(5);
    expect_next(1'b0, "R6 short high pulse");
    settle(1'b0);
    settle(1'b1);
    ticks(5);
    expect_next(1'b0, "R5 restart after change");
    ticks(1);
    expect_next(1'b1, "R5 accepted after restart");

    // zero count acts as one unit
    set_cfg(2'b11, 1'b0, 1'b0, 4'd0);
    threshold_run(1'b0, 2, "R4 zero count");

    set_cfg(2'b11, 1'b0, 1'b1, 4'd2);
    threshold_run(1'b1, 16, "R3 scale 01");
    set_cfg(2'b11, 1'b1, 1'b0, 4'd1);
    threshold_run(1'b0, 512, "R3 scale 10");
    set_cfg(2'b11, 1'b1, 1'b1, 4'd1);
    threshold_run(1'b1, 2048, "R3 scale 11");
    set_cfg(2'b11, 1'b0, 1'b0, 4'd15);
    threshold_run(1'b0, 30, "R4 max count");

    // keep low pulses
    set_cfg(2'b01, 1'b0, 1'b0, 4'd3);
    threshold_run(1'b1, 6, "R7 rise filtered");
    pin_raw = 1'b0;
    @(negedge clk);
    pin_raw = 1'b1;
    @(negedge clk);
    expect_next(1'b0, "R7 low pulse passes");
    ticks(5);
    expect_next(1'b0, "R7 rise after pulse short");
    ticks(1);
    expect_next(1'b1, "R7 rise after pulse accepted");

    // keep high pulses
    set_cfg(2'b10, 1'b0, 1'b0, 4'd3);
    threshold_run(1'b0, 6, "R8 fall filtered");
    pin_raw = 1'b1;
    @(negedge clk);
    pin_raw = 1'b0;
    @(negedge clk);
    expect_next(1'b1, "R8 high pulse passes");
    ticks(5);
    expect_next(1'b1, "R8 fall after pulse short");
    ticks(1);
    expect_next(1'b0, "R8 fall after pulse accepted");

    // bypass
    set_cfg(2'b00, 1'b0, 1'b0, 4'd3);
    pin_raw = 1'b1;
    @(negedge clk);
    expect_next(1'b0, "R2 bypass before third edge");
    expect_next(1'b1, "R2 bypass on third edge");
    pin_raw = 1'b0;
    rtc_tick = 1'b1;
    @(negedge clk);
    pin_raw = 1'b1;
    rtc_tick = 1'b0;
    expect_next(1'b1, "R2 pulse not yet");
    expect_next(1'b0, "R2 one-cycle pulse passes");
    expect_next(1'b1, "R2 pulse ends");

    // reset while output is high
    rst_n = 1'b0;
    expect_next(1'b0, "R1 reset clears output");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: cycle %0d expected=finished", ncyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule